// File: doc/BRIEF.md
# Serial DAC Write Frame Generator

This block sits on the host side of a three-wire write-only link to an 8-bit voltage-output converter. A client hands it one request at a time on a valid/ready handshake. Each request carries an 8-bit output code and a 2-bit power mode. The block packs these into a 16-bit word and drops the frame-sync line low. It then shifts the word out most significant bit first on a divided serial clock that idles low. Data changes only when that clock rises, so the receiver can sample it on the falling edge.

After the sixteenth falling edge the serial clock stays low for one more half period. Sync then rises and is held high for a programmable number of system cycles, the minimum high time the receiver needs before the next frame. After that gap sync returns low, so the lines idle low between writes. An abort input raises sync before the sixteenth falling edge, which makes the receiver drop the partial word. A done strobe marks only frames that went out in full. The serial clock half period, in system cycles, is a parameter. It should be chosen so that the serial rate stays at or below 30 MHz and each phase lasts at least 13 ns.

Top module: `dacwr_framer`

## Requirements
- R1: While reset is asserted and right after it, dac_sync, dac_sclk, dac_sdo and frame_done are 0 and req_ready is 1.
- R2: The shifted word has 16 bits and goes out MSB first. Word bits 15:14 are 0, bits 13:12 carry req_mode, bits 11:4 carry req_code and bits 3:0 are 0. dac_sdo presents word bit 15 from the cycle after acceptance.
- R3: dac_sclk is 0 for HALF_DIV cycles after acceptance. It then toggles every HALF_DIV cycles until exactly 16 rising and 16 falling edges have occurred, and it stays 0 for HALF_DIV cycles after the last fall.
- R4: dac_sdo changes only in the cycle where dac_sclk rises, or at the start or end of a frame. It is therefore stable across every falling edge.
- R5: dac_sync is 0 from acceptance until the frame ends. It is then 1 for exactly GAP_CYC cycles and returns to 0.
- R6: req_ready is 1 only while no frame or gap is in progress. A request is accepted when req_valid and req_ready are both 1 at a clock edge. Once a request is accepted, req_ready stays 0 until the gap ends. While req_valid is 0, no frame starts.
- R7: If abort_i is 1 at a clock edge during a frame, before the 16th falling edge, dac_sync is 1 in the next cycle with dac_sclk and dac_sdo at 0. The normal gap follows, frame_done does not pulse and the receiver keeps no word. abort_i has no effect when no frame is active, during the gap, or after the 16th falling edge.
- R8: frame_done is a one-cycle pulse in the first cycle of the gap, and only after a complete 16-bit frame.
- R9: Whenever dac_sync is 1 or req_ready is 1, dac_sclk and dac_sdo are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_code | input | 8 | Output code to send |
| req_mode | input | 2 | Power mode field to send |
| abort_i | input | 1 | Cut the frame in progress |
| frame_done | output | 1 | Pulse after a complete frame |
| dac_sync | output | 1 | Frame sync, low while shifting |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data, changes on rising clock |

## Verification
The hardest case to reach from the ports is an abort near the end of a frame. An abort one edge before the 16th fall must cut the frame. Once the 16th fall has happened it must be ignored, even though sync is still low and the serial clock looks idle. The stimulus decodes the serial lines as a receiver would and counts falling edges. It raises abort_i in the exact cycle after the count reaches 16, and separately partway through a frame. It also raises abort_i during the gap and while idle. A cycle-level reference model shows whether each abort should have been taken.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CODE_BITS  = 8;
  localparam int unsigned MODE_BITS  = 2;
  localparam int unsigned LEAD_PAD   = 2;
  localparam int unsigned TAIL_PAD   = FRAME_BITS - LEAD_PAD - MODE_BITS - CODE_BITS;
  localparam int unsigned HALF_EDGES = 2 * FRAME_BITS;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } fsm_e;

  typedef logic [FRAME_BITS-1:0] frame_t;

  // padding positions are driven as zero
  function automatic frame_t pack_frame(input logic [CODE_BITS-1:0] code,
                                        input logic [MODE_BITS-1:0] mode);
    frame_t f;
    f = '0;
    f[FRAME_BITS-1-LEAD_PAD -: MODE_BITS] = mode;
    f[TAIL_PAD +: CODE_BITS]              = code;
    return f;
  endfunction

  // a rising step that starts bit 1..FRAME_BITS-1 moves the register
  function automatic logic shifts_on_step(input int unsigned edges_done);
    return (edges_done % 2 == 0) && (edges_done >= 2) && (edges_done < HALF_EDGES);
  endfunction

endpackage

// File: rtl/dacwr_span_counter.sv
module dacwr_span_counter #(
  parameter int unsigned SPAN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(SPAN - 1);

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dacwr_serializer.sv
module dacwr_serializer import dacwr_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame_in,
  input  logic   shift,
  input  logic   clear,
  output logic   sdo
);
  frame_t sreg_q;

  assign sdo = sreg_q[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= frame_in;
    end else if (clear) begin
      sreg_q <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dacwr_framer.sv
module dacwr_framer import dacwr_pkg::*; #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_CYC  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CODE_BITS-1:0] req_code,
  input  logic [MODE_BITS-1:0] req_mode,
  input  logic                 abort_i,
  output logic                 frame_done,
  output logic                 dac_sync,
  output logic                 dac_sclk,
  output logic                 dac_sdo
);
  localparam int unsigned EC_W = $clog2(HALF_EDGES + 1);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(HALF_EDGES);

  fsm_e            state_q, state_d;
  logic [EC_W-1:0] edge_cnt;
  logic            sclk_q;
  logic            done_q;

  // named events
  logic in_shift;
  logic accept;
  logic half_tick;
  logic gap_expire;
  logic abort_take;
  logic frame_end;
  logic step;
  logic rise_shift;

  assign req_ready  = (state_q == ST_IDLE);
  assign in_shift   = (state_q == ST_SHIFT);
  assign accept     = req_valid && req_ready;
  assign abort_take = in_shift && abort_i && (edge_cnt < EC_LAST);
  assign frame_end  = in_shift && !abort_take && half_tick && (edge_cnt == EC_LAST);
  assign step       = in_shift && !abort_take && half_tick && (edge_cnt != EC_LAST);
  assign rise_shift = step && shifts_on_step(int'(edge_cnt));

  dacwr_span_counter #(.SPAN(HALF_DIV)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_shift),
    .last (half_tick)
  );

  dacwr_span_counter #(.SPAN(GAP_CYC)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_GAP),
    .last (gap_expire)
  );

  dacwr_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .frame_in(pack_frame(req_code, req_mode)),
    .shift   (rise_shift),
    .clear   (abort_take || frame_end),
    .sdo     (dac_sdo)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SHIFT;
      ST_SHIFT: if (abort_take || frame_end) state_d = ST_GAP;
      ST_GAP:   if (gap_expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= frame_end;
      if (!in_shift) begin
        edge_cnt <= '0;
      end else if (step) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
      if (!in_shift || abort_take || frame_end) begin
        sclk_q <= 1'b0;
      end else if (step) begin
        sclk_q <= ~sclk_q;
      end
    end
  end

  assign dac_sync   = (state_q == ST_GAP);
  assign dac_sclk   = sclk_q;
  assign frame_done = done_q;

endmodule

// File: rtl/dacwr_framer_chk.sv
module dacwr_framer_chk import dacwr_pkg::*; #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_CYC  = 4,
  parameter int unsigned EC_W     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            abort_i,
  input logic            frame_done,
  input logic            dac_sync,
  input logic            dac_sclk,
  input logic            dac_sdo,
  input logic [EC_W-1:0] edge_cnt
);
  logic [15:0] sync_run;
  logic [15:0] sclk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_run <= '0;
      sclk_run <= '0;
    end else begin
      sync_run <= dac_sync ? sync_run + 1'b1 : 16'd0;
      sclk_run <= dac_sclk ? sclk_run + 1'b1 : 16'd0;
    end
  end

  a_r6_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !dac_sync && !dac_sclk));

  a_r9_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sync || req_ready) |-> (!dac_sclk && !dac_sdo));

  a_r4_sdo_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_sclk) && !dac_sync) |-> $stable(dac_sdo));

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_sclk) && !dac_sync) |-> (sclk_run == 16'(HALF_DIV)));

  a_r5_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sync) |-> (sync_run == 16'(GAP_CYC)));

  a_r7_abort_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_sync && !req_ready && abort_i && (edge_cnt < EC_W'(HALF_EDGES)))
      |=> (dac_sync && !frame_done));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r8_done_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (dac_sync && $rose(dac_sync)));

endmodule

bind dacwr_framer dacwr_framer_chk #(
  .HALF_DIV(HALF_DIV),
  .GAP_CYC (GAP_CYC),
  .EC_W    (EC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .abort_i   (abort_i),
  .frame_done(frame_done),
  .dac_sync  (dac_sync),
  .dac_sclk  (dac_sclk),
  .dac_sdo   (dac_sdo),
  .edge_cnt  (edge_cnt)
);

// File: tb/dacwr_framer_tb_top.sv
module dacwr_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 2;
  localparam int G  = 4;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic [1:0] req_mode = 2'b00;
  logic       abort_i = 1'b0;
  logic       req_ready, frame_done, dac_sync, dac_sclk, dac_sdo;

  int n_vec = 0;
  int n_bad = 0;

  dacwr_framer #(.HALF_DIV(H), .GAP_CYC(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .abort_i(abort_i),
    .frame_done(frame_done), .dac_sync(dac_sync), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] word_of(input logic [7:0] c, input logic [1:0] m);
    return {2'b00, m, c, 4'b0000};
  endfunction

  task automatic chk1(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 shifting, 2 gap
  int          m_st = 0;
  int          m_t  = 0;
  int          m_g  = 0;
  logic [15:0] m_word = '0;
  logic        m_done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_g = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_st)
        0: if (req_valid) begin
             m_word = word_of(req_code, req_mode);
             m_st = 1; m_t = 0;
           end
        1: if (abort_i && (m_t / H) < 2*NB) begin
             m_st = 2; m_g = 0;
           end else begin
             m_t++;
             if (m_t == (2*NB + 1) * H) begin
               m_st = 2; m_g = 0; m_done = 1'b1;
             end
           end
        default: begin
             m_g++;
             if (m_g == G) m_st = 0;
           end
      endcase
    end
  end

  // receiver decoder and per-cycle compare
  logic        p_sclk = 1'b0, p_sdo = 1'b0, p_sync = 1'b0;
  int          rx_bits = 0;
  int          rx_frames = 0;
  logic [15:0] rx_word = '0;
  logic [15:0] rx_last = '0;
  int          s_run = 0;
  int          dn_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sync, e_sclk, e_sdo, e_ready, e_done;
      int k, j;
      e_sync = 1'b0; e_sclk = 1'b0; e_sdo = 1'b0; e_ready = 1'b0; e_done = 1'b0;
      case (m_st)
        0: e_ready = 1'b1;
        1: begin
             k = m_t / H;
             j = (k == 0) ? 0 : (k - 1) / 2;
             e_sclk = k[0];
             e_sdo  = m_word[15 - j];
           end
        default: begin
             e_sync = 1'b1;
             e_done = m_done;
           end
      endcase
      chk1("R5", "dac_sync", dac_sync, e_sync);
      chk1("R3", "dac_sclk", dac_sclk, e_sclk);
      chk1("R2", "dac_sdo", dac_sdo, e_sdo);
      chk1("R6", "req_ready", req_ready, e_ready);
      chk1("R8", "frame_done", frame_done, e_done);
      if (dac_sync || req_ready) begin
        chk1("R9", "sclk quiet", dac_sclk, 1'b0);
        chk1("R9", "sdo quiet", dac_sdo, 1'b0);
      end
      if (frame_done) dn_cnt++;
      if (!dac_sync && p_sclk && !dac_sclk) begin
        chk1("R4", "sdo across fall", dac_sdo, p_sdo);
        rx_word = {rx_word[14:0], p_sdo};
        rx_bits++;
      end
      if (dac_sync && !p_sync) begin
        if (frame_done) chk_int("R3", "falls per frame", rx_bits, NB);
        if (rx_bits == NB) begin
          rx_frames++;
          rx_last = rx_word;
        end
        rx_bits = 0;
      end
      if (dac_sync) s_run++;
      else begin
        if (p_sync) chk_int("R5", "gap length", s_run, G);
        s_run = 0;
      end
      p_sclk = dac_sclk; p_sdo = dac_sdo; p_sync = dac_sync;
    end
  end

  task automatic send(input logic [7:0] c, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_code = c; req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(req_ready && !dac_sync)) @(negedge clk);
  endtask

  task automatic pulse_abort();
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int fr, dn;
    repeat (3) @(negedge clk);
    chk1("R1", "sync in reset", dac_sync, 1'b0);
    chk1("R1", "sclk in reset", dac_sclk, 1'b0);
    chk1("R1", "sdo in reset", dac_sdo, 1'b0);
    chk1("R1", "done in reset", frame_done, 1'b0);
    chk1("R1", "ready in reset", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1", "ready after reset", req_ready, 1'b1);

    // R2 several patterns
    send(8'hA5, 2'b00); wait_idle();
    chk_int("R2", "word A5/0", int'(rx_last), int'(word_of(8'hA5, 2'b00)));
    send(8'hFF, 2'b11); wait_idle();
    chk_int("R2", "word FF/3", int'(rx_last), int'(word_of(8'hFF, 2'b11)));
    send(8'h00, 2'b01); wait_idle();
    chk_int("R2", "word 00/1", int'(rx_last), int'(word_of(8'h00, 2'b01)));
    send(8'h5A, 2'b10); wait_idle();
    chk_int("R2", "word 5A/2", int'(rx_last), int'(word_of(8'h5A, 2'b10)));
    chk_int("R8", "done count", dn_cnt, 4);
    chk_int("R3", "complete frames", rx_frames, 4);

    // R6 back to back with valid held high
    send(8'h81, 2'b01);
    req_valid = 1'b1; req_code = 8'h7E; req_mode = 2'b10;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk_int("R6", "back to back frames", rx_frames, 6);
    chk_int("R6", "second word", int'(rx_last), int'(word_of(8'h7E, 2'b10)));

    // R6 valid low: nothing starts
    req_code = 8'hC3;
    repeat (20) @(negedge clk);
    chk_int("R6", "no frame without valid", rx_frames, 6);
    chk1("R6", "still ready", req_ready, 1'b1);

    // R7 abort in idle is ignored
    pulse_abort();
    chk1("R7", "idle abort sync", dac_sync, 1'b0);

    // R7 abort part way
    fr = rx_frames; dn = dn_cnt;
    send(8'h3C, 2'b01);
    while (rx_bits != 5) @(negedge clk);
    pulse_abort();
    chk1("R7", "sync after abort", dac_sync, 1'b1);
    wait_idle();
    chk_int("R7", "aborted frame dropped", rx_frames, fr);
    chk_int("R7", "no done on abort", dn_cnt, dn);

    // R7 abort one fall before the end is honoured
    send(8'h99, 2'b00);
    while (rx_bits != 15) @(negedge clk);
    while (!dac_sclk) @(negedge clk);
    pulse_abort();
    wait_idle();
    chk_int("R7", "late abort dropped", rx_frames, fr);
    chk_int("R7", "late abort no done", dn_cnt, dn);

    // R7 abort after the 16th fall is ignored
    send(8'h42, 2'b11);
    while (rx_bits != 16) @(negedge clk);
    pulse_abort();
    wait_idle();
    chk_int("R7", "post-fall abort kept", rx_frames, fr + 1);
    chk_int("R8", "post-fall abort done", dn_cnt, dn + 1);
    chk_int("R2", "word 42/3", int'(rx_last), int'(word_of(8'h42, 2'b11)));

    // R7 abort during the gap leaves gap length alone
    send(8'h10, 2'b00);
    while (!dac_sync) @(negedge clk);
    pulse_abort();
    wait_idle();
    chk_int("R8", "gap abort done", dn_cnt, dn + 2);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule